// File: doc/BRIEF.md
# Remove-and-Insert Permutation Mutator

This block mutates a chromosome made of N city indices in a way that keeps it a valid permutation. One element, chosen by a removal position, is lifted out of the list and dropped back in at an insertion position. Every element that lies between the two positions slides one place to close the gap. The operation is a rotation of a segment. It never flips a bit or replaces a value, so each city is still present exactly once after it.

An upstream search engine supplies the chromosome, the two positions and an enable. The engine draws the positions at random and settles the mutation probability itself, then passes the result to this block as the enable. A one-cycle `start` pulse captures the inputs. The mutated chromosome is loaded into an output register, and `done` pulses on the next cycle. Positions are 1-based. Position p refers to element p-1, and element k occupies bits `[k*IDX_W +: IDX_W]` of the packed chromosome. If a position falls outside 1..N, no mutation takes place and the operation is flagged as an error.

Top module: `perm_mutator`

## Requirements
- R1: `done` is high in exactly the cycle after a cycle in which `start` was high, and low in every other cycle.
- R2: `chrom_out` and `pos_err` change only on a clock edge where `start` is high, and hold their values otherwise.
- R3: For a valid operation, the element at input index rem_pos-1 appears at output index ins_pos-1. Element k sits at bits [k*IDX_W +: IDX_W], and positions 1 and N are legal.
- R4: When ins_pos < rem_pos, each input element at index ins_pos-1 up to rem_pos-2 moves one index later. All other elements stay where they are.
- R5: When ins_pos > rem_pos, each input element at index rem_pos up to ins_pos-1 moves one index earlier. All other elements stay where they are.
- R6: When ins_pos equals rem_pos, the output equals the input.
- R7: When `mut_en` is low at `start`, the output equals the input and `pos_err` is low, whatever the positions are.
- R8: When `mut_en` is high and either position is 0 or greater than N, the output equals the input and `pos_err` is high.
- R9: When the input is a permutation of 0..N-1, the output is also a permutation of 0..N-1.
- R10: After reset, `done` and `pos_err` are low and `chrom_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures the inputs and launches one operation |
| mut_en | input | 1 | High to apply the mutation, low to pass the chromosome through |
| chrom_in | input | N*IDX_W | Packed source chromosome, element k at bits k*IDX_W |
| rem_pos | input | POS_W | 1-based position of the element to lift out |
| ins_pos | input | POS_W | 1-based position at which the element is placed |
| done | output | 1 | Single-cycle pulse, one cycle after start |
| chrom_out | output | N*IDX_W | Registered result chromosome |
| pos_err | output | 1 | The last operation had an enabled position outside 1..N |

## Verification
The bench drives the worked example. It then runs moves in both directions that touch the first and last positions. A design with an off-by-one segment bound in either direction would duplicate one city and drop another, and the permutation check would catch it. Equal positions, a low enable and out-of-range positions of zero and N+1 are each checked. A design that still shifted in those cases would change the chromosome, and a missing error flag would be reported. Idle cycles with changing inputs check that the result register holds its value without a start.

// File: rtl/pm_pkg.sv
package pm_pkg;

   // Direction of the segment rotation selected by the two positions.
   typedef enum logic [1:0] {
      MV_NONE = 2'd0,   // output equals input
      MV_BACK = 2'd1,   // insertion before removal: segment slides later
      MV_FWD  = 2'd2    // insertion after removal: segment slides earlier
   } move_e;

endpackage

// File: rtl/pm_pos_decode.sv
module pm_pos_decode
   import pm_pkg::*;
#(
   parameter int N     = 8,
   parameter int IDX_W = 3,
   parameter int POS_W = 4
) (
   input  logic             mut_en,
   input  logic [POS_W-1:0] rem_pos,
   input  logic [POS_W-1:0] ins_pos,
   output move_e            kind,
   output logic [IDX_W-1:0] rem_idx,
   output logic [IDX_W-1:0] ins_idx,
   output logic             range_err
);

   localparam logic [POS_W-1:0] POS_MAX = POS_W'(N);
   localparam logic [POS_W-1:0] POS_ONE = POS_W'(1);

   logic rem_ok, ins_ok;

   always_comb begin
      rem_ok    = (rem_pos != '0) && (rem_pos <= POS_MAX);
      ins_ok    = (ins_pos != '0) && (ins_pos <= POS_MAX);
      rem_idx   = IDX_W'(rem_pos - POS_ONE);
      ins_idx   = IDX_W'(ins_pos - POS_ONE);
      range_err = mut_en && !(rem_ok && ins_ok);
      kind      = MV_NONE;
      if (mut_en && rem_ok && ins_ok) begin
         if (ins_pos < rem_pos)      kind = MV_BACK;
         else if (ins_pos > rem_pos) kind = MV_FWD;
      end
   end

endmodule

// File: rtl/pm_lane.sv
module pm_lane
   import pm_pkg::*;
#(
   parameter int IDX_W = 3,
   parameter int J     = 0
) (
   input  move_e            kind,
   input  logic [IDX_W-1:0] rem_idx,
   input  logic [IDX_W-1:0] ins_idx,
   input  logic [IDX_W-1:0] self_v,
   input  logic [IDX_W-1:0] prev_v,
   input  logic [IDX_W-1:0] next_v,
   input  logic [IDX_W-1:0] picked_v,
   output logic [IDX_W-1:0] out_v
);

   localparam logic [IDX_W-1:0] J_I = IDX_W'(J);

   always_comb begin
      out_v = self_v;
      if (kind != MV_NONE) begin
         if (J_I == ins_idx)
            out_v = picked_v;
         else if (kind == MV_BACK && J_I > ins_idx && J_I <= rem_idx)
            out_v = prev_v;
         else if (kind == MV_FWD && J_I >= rem_idx && J_I < ins_idx)
            out_v = next_v;
      end
   end

endmodule

// File: rtl/perm_mutator.sv
module perm_mutator
   import pm_pkg::*;
#(
   parameter int N     = 8,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1,
   parameter int POS_W = $clog2(N + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               mut_en,
   input  logic [N*IDX_W-1:0] chrom_in,
   input  logic [POS_W-1:0]   rem_pos,
   input  logic [POS_W-1:0]   ins_pos,
   output logic               done,
   output logic [N*IDX_W-1:0] chrom_out,
   output logic               pos_err
);

   localparam int FLAT_W = N * IDX_W;

   // Elaboration-time parameter checks
   if (N < 2) begin : g_bad_n
      $error("perm_mutator: N must be at least 2");
   end
   if ((1 << IDX_W) < N) begin : g_bad_idx
      $error("perm_mutator: IDX_W too narrow for N");
   end
   if ((1 << POS_W) <= N) begin : g_bad_pos
      $error("perm_mutator: POS_W too narrow for N");
   end

   move_e            kind;
   logic [IDX_W-1:0] rem_idx, ins_idx;
   logic             range_err;
   logic [IDX_W-1:0] src   [N];
   logic [IDX_W-1:0] picked;
   logic [FLAT_W-1:0] mutated;

   pm_pos_decode #(.N(N), .IDX_W(IDX_W), .POS_W(POS_W)) u_dec (
      .mut_en   (mut_en),
      .rem_pos  (rem_pos),
      .ins_pos  (ins_pos),
      .kind     (kind),
      .rem_idx  (rem_idx),
      .ins_idx  (ins_idx),
      .range_err(range_err)
   );

   for (genvar k = 0; k < N; k++) begin : g_unpack
      assign src[k] = chrom_in[k*IDX_W +: IDX_W];
   end

   assign picked = src[rem_idx];

   for (genvar j = 0; j < N; j++) begin : g_lane
      logic [IDX_W-1:0] prev_v, next_v;
      if (j == 0) begin : g_first
         assign prev_v = src[j];
      end else begin : g_prev
         assign prev_v = src[j-1];
      end
      if (j == N - 1) begin : g_last
         assign next_v = src[j];
      end else begin : g_next
         assign next_v = src[j+1];
      end
      pm_lane #(.IDX_W(IDX_W), .J(j)) u_lane (
         .kind    (kind),
         .rem_idx (rem_idx),
         .ins_idx (ins_idx),
         .self_v  (src[j]),
         .prev_v  (prev_v),
         .next_v  (next_v),
         .picked_v(picked),
         .out_v   (mutated[j*IDX_W +: IDX_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         chrom_out <= '0;
         pos_err   <= 1'b0;
      end else begin
         done <= start;
         if (start) begin
            chrom_out <= mutated;
            pos_err   <= range_err;
         end
      end
   end

   // R1: done pulses exactly one cycle after start
   a_r1_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);
   a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);
   // R2: result holds without start
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(chrom_out) && $stable(pos_err)));
   // R7: disabled mutation passes input through, no error
   a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !mut_en) |=> (chrom_out == $past(chrom_in) && !pos_err));
   // R8: out-of-range position passes through and flags
   a_r8_range: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mut_en && (rem_pos == '0 || ins_pos == '0 ||
        rem_pos > POS_W'(N) || ins_pos > POS_W'(N)))
      |=> (chrom_out == $past(chrom_in) && pos_err));
   // R6: equal positions leave chromosome unchanged
   a_r6_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (start && rem_pos == ins_pos) |=> (chrom_out == $past(chrom_in)));

endmodule

// File: tb/tb_perm_mutator.sv
`timescale 1ns/1ps
module tb_perm_mutator;

   localparam int N  = 8;
   localparam int IW = 3;
   localparam int PW = 4;
   typedef int perm_t [N];

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic            mut_en = 1'b0;
   logic [N*IW-1:0] chrom_in = '0;
   logic [PW-1:0]   rem_pos = '0;
   logic [PW-1:0]   ins_pos = '0;
   logic            done;
   logic [N*IW-1:0] chrom_out;
   logic            pos_err;

   perm_mutator #(.N(N)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mut_en(mut_en),
      .chrom_in(chrom_in), .rem_pos(rem_pos), .ins_pos(ins_pos),
      .done(done), .chrom_out(chrom_out), .pos_err(pos_err)
   );

   int    checks = 0;
   int    fails  = 0;
   string cur_req = "R2";
   bit    run_cmp = 1'b0;

   // Reference model: list operations on a queue
   logic            exp_done;
   logic [N*IW-1:0] exp_out;
   logic            exp_err;
   logic [IW-1:0]   q [$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_done <= 1'b0;
         exp_out  <= '0;
         exp_err  <= 1'b0;
      end else begin
         exp_done <= start;
         if (start) begin
            int r, s;
            bit ok;
            logic [IW-1:0] v;
            logic [N*IW-1:0] tmp;
            r  = int'(rem_pos) - 1;
            s  = int'(ins_pos) - 1;
            ok = (r >= 0) && (r < N) && (s >= 0) && (s < N);
            q.delete();
            for (int k = 0; k < N; k++) q.push_back(chrom_in[k*IW +: IW]);
            if (mut_en && ok && r != s) begin
               v = q[r];
               q.delete(r);
               q.insert(s, v);
            end
            tmp = '0;
            for (int k = 0; k < N; k++) tmp[k*IW +: IW] = q[k];
            exp_out <= tmp;
            exp_err <= mut_en && !ok;
         end
      end
   end

   task automatic check(string req, bit ok, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && run_cmp) begin
         check("R1", done === exp_done, 64'(done), 64'(exp_done));
         check("R8", pos_err === exp_err, 64'(pos_err), 64'(exp_err));
         check(cur_req, chrom_out === exp_out, 64'(chrom_out), 64'(exp_out));
      end
   end

   function automatic logic [N*IW-1:0] pack(perm_t a);
      logic [N*IW-1:0] f = '0;
      for (int k = 0; k < N; k++) f[k*IW +: IW] = IW'(a[k]);
      return f;
   endfunction

   task automatic check_perm();
      bit [N-1:0] seen = '0;
      for (int k = 0; k < N; k++) seen[chrom_out[k*IW +: IW]] = 1'b1;
      check("R9", seen == '1, 64'(seen), 64'({N{1'b1}}));
   endtask

   task automatic apply(perm_t a, int rp, int ip, bit en, string req);
      @(negedge clk);
      cur_req  = req;
      chrom_in = pack(a);
      rem_pos  = PW'(rp);
      ins_pos  = PW'(ip);
      mut_en   = en;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      #1;
      check_perm();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R1: watchdog expired, actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      perm_t ex, b;
      ex = '{1, 7, 3, 2, 0, 4, 6, 5};
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", done === 1'b0 && pos_err === 1'b0, 64'({done, pos_err}), 64'(0));
      check("R10", chrom_out === '0, 64'(chrom_out), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      run_cmp = 1'b1;

      // R4 / R3: worked example, remove 6 insert 3
      apply(ex, 6, 3, 1'b1, "R4");
      b = '{1, 7, 4, 3, 2, 0, 6, 5};
      check("R3", chrom_out === pack(b), 64'(chrom_out), 64'(pack(b)));
      // R5: remove 2 insert 7
      apply(ex, 2, 7, 1'b1, "R5");
      b = '{1, 3, 2, 0, 4, 6, 7, 5};
      check("R5", chrom_out === pack(b), 64'(chrom_out), 64'(pack(b)));
      // R3: boundary positions
      apply(ex, 1, 8, 1'b1, "R3");
      apply(ex, 8, 1, 1'b1, "R3");
      apply(ex, 1, 2, 1'b1, "R5");
      apply(ex, 8, 7, 1'b1, "R4");
      // R6: equal positions
      apply(ex, 4, 4, 1'b1, "R6");
      check("R6", chrom_out === pack(ex), 64'(chrom_out), 64'(pack(ex)));
      // R7: enable low
      apply(ex, 6, 3, 1'b0, "R7");
      check("R7", pos_err === 1'b0, 64'(pos_err), 64'(0));
      apply(ex, 0, 9, 1'b0, "R7");
      // R8: out-of-range positions
      apply(ex, 0, 3, 1'b1, "R8");
      check("R8", pos_err === 1'b1, 64'(pos_err), 64'(1));
      apply(ex, 2, 9, 1'b1, "R8");
      apply(ex, 15, 1, 1'b1, "R8");
      // R2: idle cycles with changing inputs hold the result
      cur_req = "R2";
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chrom_in = ~chrom_in;
         rem_pos  = PW'(i + 1);
         mut_en   = ~mut_en;
      end
      // R9: random permutations and positions
      for (int t = 0; t < 300; t++) begin
         perm_t a;
         for (int k = 0; k < N; k++) a[k] = k;
         for (int k = N - 1; k > 0; k--) begin
            int j, tmp;
            j = int'($urandom_range(k, 0));
            tmp = a[k]; a[k] = a[j]; a[j] = tmp;
         end
         apply(a, int'($urandom_range(N, 1)), int'($urandom_range(N, 1)),
               ($urandom_range(3, 0) != 0), (t % 2 == 0) ? "R9" : "R3");
      end
      repeat (2) @(negedge clk);
      summary();
      $finish;
   end

endmodule